// File: doc/BRIEF.md
# Asynchronous External Memory Cycle Controller

This block turns single host requests into timed read and write cycles for asynchronous parts such as SRAM, NOR flash and NAND flash, attached behind four active-low chip selects. Each chip select covers a 64 MB byte window, so the four together span 256 MB. The host presents a chip-select index, a halfword address, write data, a direction flag and two byte enables. It then waits for a one-cycle completion pulse, which carries the read data for reads.

Every access is built from three phases: address setup, an active strobe, and hold. Each chip select has its own widths for these phases, set separately for reads and for writes, through a small configuration write port. Each chip select also has these per-select options:
- a bus turnaround gap;
- an 8- or 16-bit device width;
- a mode in which the chip select is asserted only while the strobe is active;
- a mode in which a synchronized wait input lengthens the strobe.

A new configuration is copied into the sequencer only when an access starts, so a cycle in progress keeps the timing it began with.

Top module: `amc_top`

## Requirements
- R1: After reset, all chip selects, the read strobe and the write strobe are high, the data drive enable is low, the request port is ready, no completion pulse is given, and every chip select's configuration is zero.
- R2: The configuration word has these fields: read setup [3:0], read strobe [7:4], read hold [11:8], write setup [15:12], write strobe [19:16], write hold [23:20], turnaround [27:24], 16-bit width [28], strobe-only select [29] and wait enable [30]. An access accepted at a clock edge shows S setup cycles, then W strobe cycles, then H hold cycles, using the read or the write fields of its own chip select. Only the strobe that matches the direction goes low.
- R3: A phase width programmed as zero lasts exactly one cycle.
- R4: When the previous access used a different chip select or the other direction, the turnaround count of the new chip select gives that many idle cycles before setup begins. A read after a read, or a write after a write, to the same chip select starts setup at once.
- R5: Only the addressed chip select goes low. In strobe-only mode it is low exactly while the strobe is low. Otherwise it is low for the whole of setup, strobe and hold.
- R6: With wait enabled, the wait bit of the addressed chip select passes through two flops. Once the programmed strobe width has run out, the strobe is held for as long as the synchronized wait bit is high. With wait disabled, the wait input has no effect.
- R7: A 16-bit chip select performs one cycle per request. It drives active-low byte enables equal to the inverted request enables, and the byte address has bit 0 clear. An 8-bit chip select performs one byte cycle for each enabled byte, low byte first, back to back. It drives the byte on data bits 7:0, with the byte enables at 2'b10 and address bit 0 equal to the byte lane. The done pulse comes after the last cycle.
- R8: Read data is taken from the data input on the last strobe cycle. Lanes whose byte enable is clear read as zero. The done pulse lasts one cycle, in the cycle after the last hold cycle.
- R9: A configuration write made while an access is running does not change that access. It applies from the next access to that chip select.
- R10: The request port is not ready from the accepting edge until the done pulse, and it is ready again in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | 2 | Chip select whose configuration is written |
| cfg_wdata | input | 31 | Configuration word (fields in R2) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Target chip select |
| req_addr | input | 25 | Halfword address within the chip select window |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte (nonzero) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with and after done |
| mem_addr | output | 26 | Device byte address |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_be_n | output | 2 | Active-low byte enables |
| mem_dout | output | 16 | Write data to the device |
| mem_dq_oe | output | 1 | Data drive enable during a write cycle |
| mem_din | input | 16 | Read data from the device |
| mem_wait | input | 4 | Per chip select wait, active high |

## Verification
The hardest situation to reach is a strobe held open by the wait input. The two-flop delay means a wait bit raised as the strobe begins only counts once the programmed width has run out. The bench raises the wait bit on the first strobe sample and drops it a chosen number of cycles later. It predicts the final strobe length arithmetically from the synchronizer delay, and covers a long hold, a wait that arrives too late, and a wait on a chip select with waiting disabled. Turnaround is reached by ordering a sweep over chip select, width, direction and byte enables, so that same-select repeats and direction or select changes both occur. The bench works out from its own history whether the gap is due.

// File: rtl/amc_pkg.sv
package amc_pkg;
  parameter int TW = 4;          // phase width field
  parameter int DW = 16;         // device data width (8 or 16 used)

  typedef struct packed {
    logic          wait_en;
    logic          sel_strobe;
    logic          wide;
    logic [TW-1:0] turn;
    logic [TW-1:0] wr_hold;
    logic [TW-1:0] wr_strobe;
    logic [TW-1:0] wr_setup;
    logic [TW-1:0] rd_hold;
    logic [TW-1:0] rd_strobe;
    logic [TW-1:0] rd_setup;
  } cs_cfg_t;

  parameter int CFGW = $bits(cs_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD
  } amc_state_t;

  // a zero width behaves as one cycle; result is the load value of a down counter
  function automatic logic [TW-1:0] width_m1(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/amc_cfg_regs.sv
module amc_cfg_regs
  import amc_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = $clog2(NCS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CSW-1:0]       cfg_cs,
  input  logic [CFGW-1:0]      cfg_wdata,
  output cs_cfg_t [NCS-1:0]    cfg_q
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g] <= '0;
      else if (cfg_we && cfg_cs == CSW'(g))
        cfg_q[g] <= cs_cfg_t'(cfg_wdata);
    end
  end
endmodule

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wait_in,
  output logic [N-1:0] wait_s
);
  logic [N-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta   <= '0;
      wait_s <= '0;
    end else begin
      meta   <= wait_in;
      wait_s <= meta;
    end
  end
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 26,
  localparam int CSW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst,
  input  cs_cfg_t [NCS-1:0] cfg_q,
  input  logic [NCS-1:0]    wait_s,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-2:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_be_n,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_din
);
  amc_state_t     st;
  logic [TW-1:0]  cnt;
  cs_cfg_t        act;
  cs_cfg_t        c_new;
  logic           a_wr, lane, second, done_q;
  logic [CSW-1:0] a_cs;
  logic [AW-2:0]  a_addr;
  logic [DW-1:0]  a_wdata, rdata;
  logic [1:0]     a_be;
  logic           prev_valid, prev_wr;
  logic [CSW-1:0] prev_cs;
  logic [TW-1:0]  setup_w, strobe_w, hold_w;
  logic           in_cyc, cs_on;

  assign c_new    = cfg_q[req_cs];
  assign setup_w  = a_wr ? act.wr_setup  : act.rd_setup;
  assign strobe_w = a_wr ? act.wr_strobe : act.rd_strobe;
  assign hold_w   = a_wr ? act.wr_hold   : act.rd_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;  act <= '0;  a_wr <= 1'b0;  a_cs <= '0;
      a_addr <= '0;  a_wdata <= '0;  a_be <= '0;  lane <= 1'b0;  second <= 1'b0;
      rdata <= '0;  done_q <= 1'b0;  prev_valid <= 1'b0;  prev_wr <= 1'b0;  prev_cs <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          act     <= c_new;
          a_wr    <= req_write;
          a_cs    <= req_cs;
          a_addr  <= req_addr;
          a_wdata <= req_wdata;
          a_be    <= req_be;
          rdata   <= '0;
          lane    <= !c_new.wide && !req_be[0];
          second  <= !c_new.wide && (req_be == 2'b11);
          if (prev_valid && (prev_cs != req_cs || prev_wr != req_write) && c_new.turn != '0) begin
            st  <= ST_TURN;
            cnt <= c_new.turn - 1'b1;
          end else begin
            st  <= ST_SETUP;
            cnt <= width_m1(req_write ? c_new.wr_setup : c_new.rd_setup);
          end
        end
        ST_TURN: if (cnt == '0) begin
          st <= ST_SETUP;  cnt <= width_m1(setup_w);
        end else cnt <= cnt - 1'b1;
        ST_SETUP: if (cnt == '0) begin
          st <= ST_STROBE;  cnt <= width_m1(strobe_w);
        end else cnt <= cnt - 1'b1;
        ST_STROBE: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!(act.wait_en && wait_s[a_cs])) begin
          if (!a_wr) begin
            if (act.wide)
              rdata <= {a_be[1] ? mem_din[15:8] : 8'h00, a_be[0] ? mem_din[7:0] : 8'h00};
            else if (lane) rdata[15:8] <= mem_din[7:0];
            else           rdata[7:0]  <= mem_din[7:0];
          end
          st <= ST_HOLD;  cnt <= width_m1(hold_w);
        end
        ST_HOLD: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (second) begin
          second <= 1'b0;  lane <= 1'b1;
          st <= ST_SETUP;  cnt <= width_m1(setup_w);
        end else begin
          st <= ST_IDLE;  done_q <= 1'b1;
          prev_valid <= 1'b1;  prev_cs <= a_cs;  prev_wr <= a_wr;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_cyc    = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
  assign cs_on     = act.sel_strobe ? (st == ST_STROBE) : in_cyc;
  assign mem_cs_n  = cs_on ? ~(NCS'(1) << a_cs) : '1;
  assign mem_oe_n  = !((st == ST_STROBE) && !a_wr);
  assign mem_we_n  = !((st == ST_STROBE) && a_wr);
  assign mem_dq_oe = in_cyc && a_wr;
  assign mem_addr  = {a_addr, act.wide ? 1'b0 : lane};
  assign mem_be_n  = act.wide ? ~a_be : 2'b10;
  assign mem_dout  = act.wide ? a_wdata : {8'h00, lane ? a_wdata[15:8] : a_wdata[7:0]};
  assign req_ready = (st == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata;

  // R5: never more than one chip select low
  a_r5_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));
  // R2: read and write strobes never low together
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R5: an active strobe always has a chip select low
  a_r5_strobe_has_cs: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R8: done follows the final hold cycle
  a_r8_done_after_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |-> ($past(st) == ST_HOLD));
  // R9: captured timing does not move during a running access
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(act));
  // R10: no acceptance while a cycle is on the bus
  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n != '1) |-> !req_ready);
endmodule

// File: rtl/amc_top.sv
module amc_top
  import amc_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 26,
  localparam int CSW = $clog2(NCS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CSW-1:0]  cfg_cs,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [CSW-1:0]  req_cs,
  input  logic [AW-2:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [1:0]      req_be,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [NCS-1:0]  mem_cs_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [1:0]      mem_be_n,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_din,
  input  logic [NCS-1:0]  mem_wait
);
  cs_cfg_t [NCS-1:0] cfg_q;
  logic    [NCS-1:0] wait_s;

  amc_cfg_regs #(.NCS(NCS)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cs(cfg_cs),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q));

  amc_wait_sync #(.N(NCS)) u_wsync (
    .clk(clk), .rst(rst), .wait_in(mem_wait), .wait_s(wait_s));

  amc_seq #(.NCS(NCS), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .wait_s(wait_s),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
    .mem_din(mem_din));
endmodule

// File: tb/amc_top_bench.sv
module amc_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_cs = '0;
  logic [30:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_cs = '0, req_be = 2'b11;
  logic [24:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dout, mem_din;
  logic [25:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_wait = '0;
  logic [1:0]  mem_be_n;
  logic        cur_wide = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  logic [30:0] sh [4];
  bit pv = 0, pwr = 0;
  int pcs = 0;

  always #4 clk = ~clk;

  amc_top u_amc_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
    .mem_din(mem_din), .mem_wait(mem_wait));

  function automatic logic [7:0] pat(input logic [25:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  assign mem_din = cur_wide ? {pat(mem_addr | 26'd1), pat(mem_addr & ~26'd1)}
                            : {8'h00, pat(mem_addr)};

  function automatic int effw(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [30:0] mk(input bit ew, input bit ss, input bit wide, input int tn,
      input int ws, input int ww, input int wh, input int rs, input int rw, input int rh);
    return {ew, ss, wide, 4'(tn), 4'(wh), 4'(ww), 4'(ws), 4'(rh), 4'(rw), 4'(rs)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wcfg(input int cs, input logic [30:0] v);
    @(negedge clk);
    cfg_we = 1'b1;  cfg_cs = 2'(cs);  cfg_wdata = v;
    @(posedge clk);  #1;
    cfg_we = 1'b0;
    sh[cs] = v;
  endtask

  task automatic run(input int cs, input bit wr, input logic [24:0] ha, input logic [15:0] wd,
      input logic [1:0] be, input int dwait, input bit mid, input logic [30:0] mid_val);
    logic [30:0] c;
    int s_w, st_w, h_w, tn, t_exp, nb, wl, k, done_exp, cs_exp;
    bit wide, ss, ew, stb, prev_stb;
    int first_cs, first_stb, nseg, len0, cs_cnt, wrong_cs, ss_bad, bad_dir, done_i, rdy_bad;
    logic [25:0] sa [2];
    logic [15:0] sd [2];
    logic [1:0]  sb [2];
    logic [15:0] rd, rexp;
    logic [25:0] ba;
    c = sh[cs];
    wide = c[28];  ss = c[29];  ew = c[30];  tn = int'(c[27:24]);
    s_w  = wr ? effw(c[15:12]) : effw(c[3:0]);
    st_w = wr ? effw(c[19:16]) : effw(c[7:4]);
    h_w  = wr ? effw(c[23:20]) : effw(c[11:8]);
    t_exp = (pv && (pcs != cs || pwr != wr)) ? tn : 0;
    nb = (!wide && be == 2'b11) ? 2 : 1;
    wl = st_w;
    if (ew && dwait > 0) begin
      k = st_w - 1;
      while (k >= 2 && k <= dwait + 1) k++;
      wl = k + 1;
    end
    done_exp = t_exp + (s_w + wl + h_w) + (nb - 1) * (s_w + st_w + h_w);
    cs_exp = ss ? (wl + (nb - 1) * st_w) : (nb * (s_w + h_w) + wl + (nb - 1) * st_w);
    first_cs = -1;  first_stb = -1;  nseg = 0;  len0 = 0;  cs_cnt = 0;  wrong_cs = 0;
    ss_bad = 0;  bad_dir = 0;  done_i = -1;  rdy_bad = 0;  prev_stb = 0;  rd = '0;
    sa[0] = '0; sa[1] = '0; sd[0] = '0; sd[1] = '0; sb[0] = '0; sb[1] = '0;
    cur_wide = wide;
    @(negedge clk);
    req_valid = 1'b1;  req_write = wr;  req_cs = 2'(cs);  req_addr = ha;
    req_wdata = wd;  req_be = be;
    @(posedge clk);  #1;
    req_valid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mid && i == 1) begin cfg_we = 1'b1; cfg_cs = 2'(cs); cfg_wdata = mid_val; end
      if (mid && i == 2) cfg_we = 1'b0;
      stb = !mem_oe_n || !mem_we_n;
      if (mem_cs_n != 4'hF) begin
        cs_cnt++;
        if (first_cs < 0) first_cs = i;
        if (mem_cs_n != ~(4'b0001 << cs)) wrong_cs++;
      end
      if (ss && ((mem_cs_n != 4'hF) != stb)) ss_bad++;
      if (wr ? !mem_oe_n : !mem_we_n) bad_dir++;
      if (stb && !prev_stb) begin
        if (nseg < 2) begin sa[nseg] = mem_addr; sd[nseg] = mem_dout; sb[nseg] = mem_be_n; end
        if (nseg == 0) begin
          first_stb = i;
          if (dwait > 0) mem_wait[cs] = 1'b1;
        end
        nseg++;
      end
      if (stb && nseg == 1) len0++;
      if (dwait > 0 && first_stb >= 0 && i == first_stb + dwait) mem_wait[cs] = 1'b0;
      prev_stb = stb;
      if (rsp_done) begin
        done_i = i;  rd = rsp_rdata;
        chk(req_ready == 1'b1, "R10 ready in done cycle", int'(req_ready), 1);
        break;
      end
      if (req_ready) rdy_bad++;
    end
    mem_wait = '0;
    if (done_i < 0) chk(0, "R8 done never seen", done_i, done_exp);
    chk(rdy_bad == 0, "R10 ready low while busy", rdy_bad, 0);
    chk(first_stb == t_exp + s_w, "R4 setup start / R2 setup width", first_stb, t_exp + s_w);
    chk(len0 == wl, (dwait > 0) ? "R6 strobe length with wait" : "R2 R3 strobe width", len0, wl);
    chk(done_i == done_exp, (nb == 2) ? "R7 done after both bytes" : "R8 done timing", done_i, done_exp);
    chk(bad_dir == 0, "R2 wrong strobe direction", bad_dir, 0);
    chk(wrong_cs == 0, "R5 wrong chip select", wrong_cs, 0);
    chk(cs_cnt == cs_exp, "R5 chip select active cycles", cs_cnt, cs_exp);
    if (ss) chk(ss_bad == 0, "R5 strobe-only select", ss_bad, 0);
    else    chk(first_cs == t_exp, "R4 turnaround gap", first_cs, t_exp);
    chk(nseg == nb, "R7 byte cycle count", nseg, nb);
    ba = {ha, 1'b0};
    if (wide) begin
      chk(sa[0] == ba, "R7 wide address", int'(sa[0]), int'(ba));
      if (wr) begin
        chk(sd[0] == wd, "R7 wide write data", int'(sd[0]), int'(wd));
        chk(sb[0] == ~be, "R7 wide byte enables", int'(sb[0]), int'(~be));
      end
    end else begin
      for (int s = 0; s < nb && s < 2; s++) begin
        logic ln;
        ln = (nb == 2) ? s[0] : !be[0];
        chk(sa[s] == {ha, ln}, "R7 byte address lane", int'(sa[s]), int'({ha, ln}));
        chk(sb[s] == 2'b10, "R7 narrow byte enables", int'(sb[s]), 2);
        if (wr) chk(sd[s] == {8'h00, ln ? wd[15:8] : wd[7:0]}, "R7 narrow write byte",
                    int'(sd[s]), int'({8'h00, ln ? wd[15:8] : wd[7:0]}));
      end
    end
    if (!wr) begin
      rexp = {be[1] ? pat(ba | 26'd1) : 8'h00, be[0] ? pat(ba) : 8'h00};
      chk(rd == rexp, "R8 read data", int'(rd), int'(rexp));
    end
    pv = 1;  pcs = cs;  pwr = wr;
    if (mid) sh[cs] = mid_val;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n == 4'hF, "R1 chip selects idle", int'(mem_cs_n), 15);
    chk(mem_oe_n && mem_we_n, "R1 strobes idle", int'({mem_oe_n, mem_we_n}), 3);
    chk(!mem_dq_oe, "R1 data drive off", int'(mem_dq_oe), 0);
    chk(req_ready && !rsp_done, "R1 ready and no done", int'({req_ready, rsp_done}), 2);
    // R1 R3: zero reset configuration gives one-cycle phases on an 8-bit select
    run(0, 0, 25'h0012, 16'h0, 2'b01, 0, 0, '0);
    // sweep: chip select x width x direction x byte enables
    for (int cs = 0; cs < 4; cs++)
      for (int w = 0; w < 2; w++) begin
        wcfg(cs, mk(0, cs[0], w[0], cs + w, 3 - cs, cs + 1, (cs * 2) % 4,
                    cs, (cs + 2) % 5, (cs + 1) % 3));
        for (int wr = 0; wr < 2; wr++)
          for (int b = 1; b < 4; b++)
            run(cs, wr[0], 25'h0040 + 25'(cs * 16 + b * 2 + wr), 16'hA55A ^ 16'(cs * 257 + b),
                2'(b), 0, 0, '0);
      end
    // R6: wait extension cases on chip select 2
    wcfg(2, mk(1, 0, 1, 0, 1, 5, 1, 1, 3, 1));
    run(2, 0, 25'h0100, 16'h0, 2'b11, 6, 0, '0);
    run(2, 1, 25'h0101, 16'h1234, 2'b11, 2, 0, '0);
    wcfg(2, mk(1, 0, 1, 0, 1, 1, 1, 1, 1, 1));
    run(2, 0, 25'h0102, 16'h0, 2'b11, 4, 0, '0);
    wcfg(2, mk(0, 0, 1, 0, 1, 1, 1, 2, 3, 2));
    run(2, 0, 25'h0103, 16'h0, 2'b10, 5, 0, '0);
    // R9: configuration written mid-access applies only to the next access
    wcfg(1, mk(0, 0, 1, 2, 1, 1, 1, 3, 2, 2));
    run(1, 0, 25'h0200, 16'h0, 2'b11, 0, 1, mk(0, 0, 1, 2, 1, 1, 1, 1, 6, 1));
    run(1, 0, 25'h0201, 16'h0, 2'b11, 0, 0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;  fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule